// File: doc/BRIEF.md
# Strobed Handshake Port Channel

This block runs one 8-bit parallel port of a peripheral interface controller in strobed handshake mode. In the input direction, a peripheral pulses an active-low strobe. The channel latches the port pins on the falling edge, sets a buffer-full flag, and asks the host for service when the strobe returns high. In the output direction, a host write loads the output latch and pulls an active-low buffer-full line low. The peripheral's active-low acknowledge releases that line, and the end of the acknowledge raises the service request.

The three handshake lines sit on fixed port C bits. The channel takes those bits over, and every other port C bit stays under the surrounding controller as plain I/O. Port selection is fixed at build time. For the second port, every direction uses bits 2 (strobe or acknowledge), 1 (buffer full) and 0 (request). For the first port, the input direction uses bits 4 (strobe), 5 (buffer full) and 3 (request), and the output direction uses bits 6 (acknowledge), 7 (buffer full, active low) and 3 (request).

The request enable is a flag written through the bit set/reset command, at the same bit number as the strobe or acknowledge line. Register decode and the mode bits come from the controller. When handshake mode is off, the channel acts as a plain latched-output, direct-input port.

Top module: `hs_port_channel`

## Requirements
- R1: In handshake input mode, a falling edge on the strobe line captures the port pins into the input latch and sets the buffer-full bit. The update lands SYNC_STAGES+1 clock edges after the pin changes. Host reads return the latched value until the next strobe.
- R2: In handshake input mode, the request output rises when the strobe returns high while the buffer-full bit is set and the request enable is 1. If the buffer was emptied before the strobe rose, no request is raised.
- R3: A host read (host_rd high for one cycle) in handshake input mode clears both the buffer-full bit and the request at the next clock edge.
- R4: A host write in handshake output mode does three things at the next edge: it loads port_out with the written data, drives the active-low buffer-full bit to 0, and clears the request. port_oe is 1 whenever the direction is output.
- R5: In handshake output mode, a falling edge on the acknowledge line returns the buffer-full bit to 1. The following rising edge of the acknowledge line raises the request if the request enable is 1.
- R6: A set/reset command (bsr_we high, bsr_sel the bit number, bsr_set the value) aimed at the strobe or acknowledge bit number writes the request enable. A command aimed at any other bit number leaves pc_out and pc_rd of the channel unchanged.
- R7: While handshake mode is on, the strobe or acknowledge bit is an input (pc_oe 0 and pc_out 0). The buffer-full and request bits are driven (pc_oe 1). Every other bit of pc_out and pc_oe follows pc_gp_out and pc_gp_oe. The bit positions are the ones given above.
- R8: While handshake mode is on, pc_rd returns the buffer-full bit, the request and the request enable at the buffer-full, request and strobe positions. All other bits of pc_rd are the port C pins.
- R9: While handshake mode is off: irq is 0, pc_out and pc_oe equal pc_gp_out and pc_gp_oe, strobe pulses have no effect, host reads in the input direction return port_in directly, and all handshake state is cleared.
- R10: The request never rises unless the request enable was 1 in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_hs_en | input | 1 | Handshake mode on for this port |
| cfg_dir_in | input | 1 | 1: input direction, 0: output direction |
| host_wr | input | 1 | One-cycle host write to this port |
| host_rd | input | 1 | One-cycle host read of this port |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data |
| bsr_we | input | 1 | Port C bit set/reset command strobe |
| bsr_sel | input | 3 | Port C bit number of the command |
| bsr_set | input | 1 | Value written by the command |
| port_in | input | DATA_W | Port pins, inbound |
| port_out | output | DATA_W | Port output latch |
| port_oe | output | 1 | Port output enable |
| pc_in | input | 8 | Port C pins, inbound |
| pc_gp_out | input | 8 | Controller's plain port C output values |
| pc_gp_oe | input | 8 | Controller's plain port C output enables |
| pc_out | output | 8 | Port C output values after handshake takeover |
| pc_oe | output | 8 | Port C output enables after handshake takeover |
| pc_rd | output | 8 | Port C read-back value |
| irq | output | 1 | Service request to the host |

## Verification
Five properties are checked on every cycle:
- a write arms the output buffer and clears the request;
- a read clears the input request;
- the request never rises without the enable;
- the handshake bits always have the right drive directions;
- the channel stays transparent while handshake mode is off.

Only the bench scenarios can show the data side and the edge-driven sequences. These include capturing the correct pin value on the strobe edge, keeping it after the pins change, the acknowledge pair moving buffer-full and then the request, the read-before-strobe-rise case, the read-back layout, and the alternative bit mapping of the second port.

// File: rtl/hs_pkg.sv
// Shared types for the handshake port channel.
// Holds the port C bit map for each port/direction pairing.
package hs_pkg;

    localparam int unsigned PC_W = 8;

    // Port C bit numbers of the three handshake lines
    typedef struct packed {
        logic [2:0] stb;   // strobe (input) or acknowledge (output); also enable position
        logic [2:0] full;  // buffer-full line
        logic [2:0] irq;   // service request line
    } hs_map_t;

    // Picks the fixed bit positions for the given port and direction
    function automatic hs_map_t hs_map(input logic is_b, input logic dir_in);
        hs_map_t m;
        if (is_b) begin
            m.stb  = 3'd2;
            m.full = 3'd1;
            m.irq  = 3'd0;
        end else if (dir_in) begin
            m.stb  = 3'd4;
            m.full = 3'd5;
            m.irq  = 3'd3;
        end else begin
            m.stb  = 3'd6;
            m.full = 3'd7;
            m.irq  = 3'd3;
        end
        return m;
    endfunction

endpackage

// File: rtl/hs_edge_sync.sv
// Synchronises an asynchronous active-low handshake pin and flags its edges.
// Assumes the pin idles high; the chain and the edge register reset to 1.
// Edges are reported one cycle wide, STAGES edges after the pin changes.
module hs_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall,
    output logic rise
);
    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the pin through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], pin};
    end

    // Remember the last synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[TOP];
    end

    assign fall = prev & ~chain[TOP];
    assign rise = ~prev & chain[TOP];

endmodule

// File: rtl/hs_in_path.sv
// Inbound half of the channel: latch on strobe fall, buffer-full flag, request.
// Assumes edges are already synchronised. All flags are held clear while en is low.
// A strobe fall wins over a same-cycle read for the full flag.
// A read wins over a same-cycle strobe rise for the request.
module hs_in_path #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              stb_fall,
    input  logic              stb_rise,
    input  logic              inte,
    input  logic              rd,
    input  logic [DATA_W-1:0] pins,
    output logic [DATA_W-1:0] data,
    output logic              ibf,
    output logic              irq
);
    // Capture the pins on each accepted strobe fall
    always_ff @(posedge clk) begin
        if (!rst_n)             data <= '0;
        else if (en && stb_fall) data <= pins;
    end

    // Buffer-full flag: set by strobe, cleared by host read
    always_ff @(posedge clk) begin
        if (!rst_n || !en) ibf <= 1'b0;
        else if (stb_fall) ibf <= 1'b1;
        else if (rd)       ibf <= 1'b0;
    end

    // Request: raised at end of strobe if full and enabled, dropped by read
    always_ff @(posedge clk) begin
        if (!rst_n || !en)                 irq <= 1'b0;
        else if (rd)                       irq <= 1'b0;
        else if (stb_rise && ibf && inte)  irq <= 1'b1;
    end

endmodule

// File: rtl/hs_out_path.sv
// Outbound half of the channel: output latch, active-low buffer-full, request.
// Assumes edges are already synchronised. The latch loads on any write, and the
// handshake flags work only while en is high. A write wins over a same-cycle
// acknowledge.
module hs_out_path #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_fall,
    input  logic              ack_rise,
    input  logic              inte,
    output logic [DATA_W-1:0] data,
    output logic              obf_n,
    output logic              irq
);
    // Output latch loads on every host write
    always_ff @(posedge clk) begin
        if (!rst_n)  data <= '0;
        else if (wr) data <= wdata;
    end

    // Active-low buffer-full: pulled low by write, released by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n || !en) obf_n <= 1'b1;
        else if (wr)       obf_n <= 1'b0;
        else if (ack_fall) obf_n <= 1'b1;
    end

    // Request: raised at end of acknowledge once buffer released, dropped by write
    always_ff @(posedge clk) begin
        if (!rst_n || !en)                  irq <= 1'b0;
        else if (wr)                        irq <= 1'b0;
        else if (ack_rise && obf_n && inte) irq <= 1'b1;
    end

endmodule

// File: rtl/hs_port_channel.sv
// Strobed handshake channel for one 8-bit port of a parallel interface.
// Assumes the controller supplies the decoded host strobes, the mode and
// direction bits, the set/reset command and the plain port C drive values.
// The handshake bit positions come from hs_pkg::hs_map.
module hs_port_channel
    import hs_pkg::*;
#(
    parameter bit          IS_PORT_B   = 1'b0,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_hs_en,
    input  logic              cfg_dir_in,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              bsr_we,
    input  logic [2:0]        bsr_sel,
    input  logic              bsr_set,
    input  logic [DATA_W-1:0] port_in,
    output logic [DATA_W-1:0] port_out,
    output logic              port_oe,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [PC_W-1:0]   pc_gp_out,
    input  logic [PC_W-1:0]   pc_gp_oe,
    output logic [PC_W-1:0]   pc_out,
    output logic [PC_W-1:0]   pc_oe,
    output logic [PC_W-1:0]   pc_rd,
    output logic              irq
);
    hs_map_t           map;
    logic              in_en, out_en;
    logic              hs_pin, hs_fall, hs_rise;
    logic              inte_q;
    logic [DATA_W-1:0] in_data, out_data;
    logic              ibf, in_irq, obf_n, out_irq, full_bit;

    assign map    = hs_map(IS_PORT_B, cfg_dir_in);
    assign in_en  = cfg_hs_en & cfg_dir_in;
    assign out_en = cfg_hs_en & ~cfg_dir_in;
    assign hs_pin = pc_in[map.stb];

    hs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (hs_pin),
        .fall (hs_fall),
        .rise (hs_rise)
    );

    // Request enable, written by set/reset commands at the strobe position
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_hs_en)            inte_q <= 1'b0;
        else if (bsr_we && bsr_sel == map.stb) inte_q <= bsr_set;
    end

    hs_in_path #(.DATA_W(DATA_W)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (in_en),
        .stb_fall(hs_fall),
        .stb_rise(hs_rise),
        .inte    (inte_q),
        .rd      (host_rd),
        .pins    (port_in),
        .data    (in_data),
        .ibf     (ibf),
        .irq     (in_irq)
    );

    hs_out_path #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (out_en),
        .wr      (host_wr),
        .wdata   (host_wdata),
        .ack_fall(hs_fall),
        .ack_rise(hs_rise),
        .inte    (inte_q),
        .data    (out_data),
        .obf_n   (obf_n),
        .irq     (out_irq)
    );

    assign irq      = (in_en & in_irq) | (out_en & out_irq);
    assign full_bit = cfg_dir_in ? ibf : obf_n;
    assign port_out = out_data;
    assign port_oe  = ~cfg_dir_in;

    // Host read data: latched in handshake input, raw pins in plain input
    always_comb begin
        if (!cfg_dir_in)    host_rdata = out_data;
        else if (cfg_hs_en) host_rdata = in_data;
        else                host_rdata = port_in;
    end

    // Port C takeover of the three handshake bits and their read-back
    always_comb begin
        pc_out = pc_gp_out;
        pc_oe  = pc_gp_oe;
        pc_rd  = pc_in;
        if (cfg_hs_en) begin
            pc_out[map.stb]  = 1'b0;
            pc_oe[map.stb]   = 1'b0;
            pc_out[map.full] = full_bit;
            pc_oe[map.full]  = 1'b1;
            pc_out[map.irq]  = irq;
            pc_oe[map.irq]   = 1'b1;
            pc_rd[map.stb]   = inte_q;
            pc_rd[map.full]  = full_bit;
            pc_rd[map.irq]   = irq;
        end
    end

endmodule

// File: rtl/hs_port_channel_chk.sv
// Assertion checker for hs_port_channel, attached by bind below.
// Assumes the same IS_PORT_B as the bound instance.
module hs_port_channel_chk
    import hs_pkg::*;
#(
    parameter bit IS_PORT_B = 1'b0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_hs_en,
    input logic            cfg_dir_in,
    input logic            host_wr,
    input logic            host_rd,
    input logic [PC_W-1:0] pc_gp_out,
    input logic [PC_W-1:0] pc_gp_oe,
    input logic [PC_W-1:0] pc_out,
    input logic [PC_W-1:0] pc_oe,
    input logic            irq,
    input logic            inte
);
    hs_map_t m;
    assign m = hs_map(IS_PORT_B, cfg_dir_in);

    AST_WR_ARMS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hs_en && !cfg_dir_in && host_wr) |=> (!cfg_hs_en || cfg_dir_in || (!pc_out[m.full] && !irq))); // R4

    AST_RD_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hs_en && cfg_dir_in && host_rd) |=> (!cfg_hs_en || !cfg_dir_in || !irq)); // R3

    AST_IRQ_NEEDS_INTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(inte)); // R10

    AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_hs_en |-> (pc_out == pc_gp_out && pc_oe == pc_gp_oe && !irq)); // R9

    AST_HS_DIRECTIONS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hs_en |-> (!pc_oe[m.stb] && pc_oe[m.full] && pc_oe[m.irq])); // R7

endmodule

bind hs_port_channel hs_port_channel_chk #(.IS_PORT_B(IS_PORT_B)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_hs_en (cfg_hs_en),
    .cfg_dir_in(cfg_dir_in),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .pc_gp_out (pc_gp_out),
    .pc_gp_oe  (pc_gp_oe),
    .pc_out    (pc_out),
    .pc_oe     (pc_oe),
    .irq       (irq),
    .inte      (inte_q)
);

// File: tb/test_hs_port_channel.sv
// Self-checking bench: vector table walked in both directions, then directed cases.
module test_hs_port_channel;

    typedef struct packed {
        logic [7:0] data;
        logic       inte;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'hA5, 1'b1}, '{8'h00, 1'b1}, '{8'hFF, 1'b0},
        '{8'h3C, 1'b1}, '{8'h81, 1'b0}, '{8'h5A, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_hs_en, cfg_dir_in, host_wr, host_rd;
    logic [7:0] host_wdata, host_rdata, host_rdata_b;
    logic       bsr_we, bsr_set;
    logic [2:0] bsr_sel;
    logic [7:0] port_in, port_out, port_out_b;
    logic       port_oe, port_oe_b;
    logic [7:0] pc_in, pc_in_b, pc_gp_out, pc_gp_oe;
    logic [7:0] pc_out, pc_oe, pc_rd, pc_out_b, pc_oe_b, pc_rd_b;
    logic       irq, irq_b;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    hs_port_channel i_hs_port_channel (
        .clk(clk), .rst_n(rst_n), .cfg_hs_en(cfg_hs_en), .cfg_dir_in(cfg_dir_in),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .bsr_we(bsr_we), .bsr_sel(bsr_sel), .bsr_set(bsr_set),
        .port_in(port_in), .port_out(port_out), .port_oe(port_oe),
        .pc_in(pc_in), .pc_gp_out(pc_gp_out), .pc_gp_oe(pc_gp_oe),
        .pc_out(pc_out), .pc_oe(pc_oe), .pc_rd(pc_rd), .irq(irq)
    );

    hs_port_channel #(.IS_PORT_B(1'b1)) i_hs_port_channel_b (
        .clk(clk), .rst_n(rst_n), .cfg_hs_en(cfg_hs_en), .cfg_dir_in(cfg_dir_in),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata_b),
        .bsr_we(bsr_we), .bsr_sel(bsr_sel), .bsr_set(bsr_set),
        .port_in(port_in), .port_out(port_out_b), .port_oe(port_oe_b),
        .pc_in(pc_in_b), .pc_gp_out(pc_gp_out), .pc_gp_oe(pc_gp_oe),
        .pc_out(pc_out_b), .pc_oe(pc_oe_b), .pc_rd(pc_rd_b), .irq(irq_b)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bsr(input logic [2:0] sel, input logic val);
        bsr_we = 1'b1; bsr_sel = sel; bsr_set = val;
        tick(1);
        bsr_we = 1'b0;
    endtask

    task automatic host_read();
        host_rd = 1'b1;
        tick(1);
        host_rd = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] d);
        host_wr = 1'b1; host_wdata = d;
        tick(1);
        host_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cfg_hs_en = 1'b0; cfg_dir_in = 1'b1;
        host_wr = 1'b0; host_rd = 1'b0; host_wdata = 8'h00;
        bsr_we = 1'b0; bsr_sel = 3'd0; bsr_set = 1'b0;
        port_in = 8'h3C; pc_in = 8'h50; pc_in_b = 8'h04;
        pc_gp_out = 8'hFF; pc_gp_oe = 8'h00;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R9: reset and disabled state
        chk("R9 irq", {7'd0, irq}, 8'h00);
        chk("R9 pc_out", pc_out, 8'hFF);
        chk("R9 pc_oe", pc_oe, 8'h00);
        chk("R9 raw read", host_rdata, 8'h3C);
        pc_in[4] = 1'b0; tick(5); pc_in[4] = 1'b1; tick(5);
        chk("R9 strobe ignored irq", {7'd0, irq}, 8'h00);
        chk("R9 strobe ignored pc_out", pc_out, 8'hFF);

        // Enter handshake input mode
        cfg_hs_en = 1'b1; cfg_dir_in = 1'b1;
        tick(1);
        chk("R7 in oe map", pc_oe, 8'h28);
        chk("R7 in out map", pc_out, 8'hC7);
        chk("R7 port B oe map", pc_oe_b, 8'h03);
        chk("R8 readback idle", pc_rd, 8'h40);

        // R6: command to the buffer-full bit has no effect
        bsr(3'd5, 1'b1);
        chk("R6 ignored pc_out", pc_out, 8'hC7);
        chk("R6 ignored pc_rd", pc_rd, 8'h40);

        // R1: port B captures on its own strobe bit
        port_in = 8'h96;
        pc_in_b[2] = 1'b0; tick(5);
        chk("R1 port B full", {7'd0, pc_out_b[1]}, 8'h01);
        chk("R1 port B data", host_rdata_b, 8'h96);
        pc_in_b[2] = 1'b1; tick(5);

        // Input-direction vector walk
        for (int i = 0; i < NV; i++) begin
            bsr(3'd4, VECS[i].inte);
            port_in = VECS[i].data;
            pc_in[4] = 1'b0; tick(5);
            chk("R1 full set", {7'd0, pc_out[5]}, 8'h01);
            chk("R1 captured", host_rdata, VECS[i].data);
            pc_in[4] = 1'b1; tick(5);
            chk("R2 irq", {7'd0, irq}, {7'd0, VECS[i].inte});
            chk("R8 readback", pc_rd, {2'b01, 1'b1, VECS[i].inte, VECS[i].inte, 3'b000});
            port_in = ~VECS[i].data; tick(1);
            chk("R1 held", host_rdata, VECS[i].data);
            host_read(); 
            chk("R3 full clear", {7'd0, pc_out[5]}, 8'h00);
            chk("R3 irq clear", {7'd0, irq}, 8'h00);
        end

        // R2 corner: buffer emptied before strobe returns high
        bsr(3'd4, 1'b1);
        pc_in[4] = 1'b0; tick(5);
        host_read();
        pc_in[4] = 1'b1; tick(5);
        chk("R2 no irq on empty", {7'd0, irq}, 8'h00);

        // Enter handshake output mode
        cfg_dir_in = 1'b0;
        tick(1);
        chk("R7 out oe map", pc_oe, 8'h88);
        chk("R7 out out map", pc_out, 8'hB7);
        chk("R4 port_oe", {7'd0, port_oe}, 8'h01);

        // Output-direction vector walk
        for (int i = 0; i < NV; i++) begin
            bsr(3'd6, VECS[i].inte);
            host_write(VECS[i].data);
            chk("R4 data", port_out, VECS[i].data);
            chk("R4 obf low", {7'd0, pc_out[7]}, 8'h00);
            chk("R4 irq clear", {7'd0, irq}, 8'h00);
            pc_in[6] = 1'b0; tick(5);
            chk("R5 obf released", {7'd0, pc_out[7]}, 8'h01);
            chk("R5 no irq yet", {7'd0, irq}, 8'h00);
            pc_in[6] = 1'b1; tick(5);
            chk("R5 irq after ack", {7'd0, irq}, {7'd0, VECS[i].inte});
        end

        // R9: leaving handshake mode drops the request at once
        cfg_hs_en = 1'b0;
        tick(1);
        chk("R9 exit irq", {7'd0, irq}, 8'h00);
        chk("R9 exit pc_out", pc_out, 8'hFF);

        finish_run();
    end

endmodule